// File: doc/BRIEF.md
# Video Sync Presence Detector

This block decides whether sync pulses are arriving on the video input that is currently selected. An external slicer delivers a one-cycle strobe for each sync pulse it sees. A slow timebase delivers a one-cycle tick. The block turns these into a single detect flag, and it has two ways of doing so.

In the sticky mode, the first sync strobe latches the flag, and a status read clears it. In the windowed mode, strobes are counted over windows of a fixed number of ticks. The flag moves only after two back-to-back windows give the same verdict against a threshold of 384 pulses, and the change waits a further half window after the second of those windows closes.

A write of the source select loads a new input code, clears the flag and restarts all window timing. Codes that select no input hold the block idle with the flag low.

Top module: `vsd_presence_det`

## Requirements
- R1: After reset the detect flag is 0 and the stored source code is 000, which counts as no input.
- R2: Source codes 001 to 110 are live inputs. Codes 000 and 111 select nothing: the flag stays 0 and sync strobes are ignored in both modes.
- R3: A select write stores src_sel_i, forces the flag to 0 on the next cycle and restarts the window timer and pulse count. It takes priority over a sync strobe or a status read in the same cycle.
- R4: In mode 0 (mode_i low, sticky), a sync strobe on a live input sets the flag on the next cycle, and the flag stays 1 while no strobes follow.
- R5: In mode 0, a status read clears the flag on the next cycle. A sync strobe in the same cycle wins, and the flag is then 1.
- R6: In mode 1 (mode_i high, windowed), a window lasts WIN_TICKS ticks counted from the last select write. Strobes are counted in the window, including a strobe in the cycle of the closing tick. The count saturates at THRESH, so a window holding more pulses than the counter range is still judged at or above threshold.
- R7: In mode 1, two consecutive windows that each hold at least THRESH (384) pulses drive the flag to 1. Exactly 384 pulses counts as enough.
- R8: In mode 1, two consecutive windows that each hold fewer than THRESH pulses drive the flag to 0. 383 pulses counts as too few.
- R9: In mode 1, when two consecutive windows disagree, the flag keeps its value.
- R10: In mode 1, a flag change takes effect on the clock edge of the WIN_TICKS/2-th tick after the closing tick of the second agreeing window, and not before.
- R11: In mode 1, a status read has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_pulse_i | input | 1 | One-cycle strobe per detected sync pulse |
| win_tick_i | input | 1 | One-cycle timebase tick; WIN_TICKS ticks form one window |
| mode_i | input | 1 | 0 = sticky, 1 = windowed count |
| src_sel_i | input | 3 | Source code, loaded on a select write |
| sel_wr_i | input | 1 | Select write strobe |
| stat_rd_i | input | 1 | Status read strobe |
| detect_o | output | 1 | Sync-present flag |

## Verification
The bench targets the threshold edges at 383 and 384 pulses. A comparator off by one in either direction makes the flag rise or fall one window pair early or late. A window of 512 pulses catches a counter that wraps instead of saturating, because the wrapped count reads as empty and hides the agreement with the next window. Sampling the flag one tick before and one tick after the half-window point catches an update applied at the window edge or at the wrong tick. A select write issued mid-window catches a timer that is not restarted, because the later update then lands on a shifted tick. Code 111 is run with full windows to catch a decoder that treats it as a seventh input, and simultaneous read and strobe, or write and strobe, pin down the priority order.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   localparam int SEL_W = 3;

   typedef enum logic {
      MODE_STICKY = 1'b0,
      MODE_WINDOW = 1'b1
   } vsd_mode_e;

   // all-zeros selects nothing, all-ones is an unused code
   function automatic logic src_is_live(input logic [SEL_W-1:0] s);
      return (s != '0) && (s != '1);
   endfunction

endpackage

// File: rtl/vsd_win_timer.sv
module vsd_win_timer #(
   parameter int WIN_TICKS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic tick,
   output logic win_end,
   output logic half_pt
);
   localparam int TW = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;
   localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);
   localparam logic [TW-1:0] MID  = TW'(WIN_TICKS / 2 - 1);

   logic [TW-1:0] tcnt;

   assign win_end = run && tick && (tcnt == LAST);
   assign half_pt = run && tick && (tcnt == MID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tcnt <= '0;
      else if (clr || !run)     tcnt <= '0;
      else if (tick) begin
         if (tcnt == LAST)      tcnt <= '0;
         else                   tcnt <= tcnt + 1'b1;
      end
   end
endmodule

// File: rtl/vsd_pulse_cnt.sv
module vsd_pulse_cnt #(
   parameter int THRESH = 384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic pulse,
   input  logic win_end,
   output logic win_hi
);
   localparam int CW = $clog2(THRESH + 1);
   localparam logic [CW-1:0] TOP  = CW'(THRESH);
   localparam logic [CW-1:0] NEAR = CW'(THRESH - 1);

   logic [CW-1:0] pcnt;

   // verdict includes a strobe arriving together with the closing tick
   assign win_hi = (pcnt == TOP) || (pulse && (pcnt == NEAR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pcnt <= '0;
      else if (clr || !run || win_end)  pcnt <= '0;
      else if (pulse && (pcnt != TOP))  pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/vsd_decide.sv
module vsd_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic win_end,
   input  logic win_hi,
   input  logic half_pt,
   output logic upd,
   output logic upd_val
);
   logic prev_vld, prev_hi, pend, pend_val;

   assign upd     = half_pt && pend;
   assign upd_val = pend_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_vld <= 1'b0;
         prev_hi  <= 1'b0;
         pend     <= 1'b0;
         pend_val <= 1'b0;
      end else if (clr || !run) begin
         prev_vld <= 1'b0;
         prev_hi  <= 1'b0;
         pend     <= 1'b0;
         pend_val <= 1'b0;
      end else begin
         if (win_end) begin
            prev_vld <= 1'b1;
            prev_hi  <= win_hi;
            if (prev_vld && (prev_hi == win_hi)) begin
               pend     <= 1'b1;
               pend_val <= win_hi;
            end
         end else if (half_pt) begin
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vsd_presence_det.sv
module vsd_presence_det
   import vsd_pkg::*;
#(
   parameter int WIN_TICKS = 40,
   parameter int THRESH    = 384
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_pulse_i,
   input  logic             win_tick_i,
   input  logic             mode_i,
   input  logic [SEL_W-1:0] src_sel_i,
   input  logic             sel_wr_i,
   input  logic             stat_rd_i,
   output logic             detect_o
);
   generate
      if (WIN_TICKS < 2 || (WIN_TICKS % 2) != 0) begin : g_bad_win
         $error("WIN_TICKS must be even and at least 2");
      end
      if (THRESH < 1) begin : g_bad_thr
         $error("THRESH must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] src_q;
   logic             src_act, run, flag_q;
   logic             win_end, half_pt, win_hi, upd, upd_val;
   vsd_mode_e        mode;

   assign mode    = vsd_mode_e'(mode_i);
   assign src_act = src_is_live(src_q);
   assign run     = src_act && (mode == MODE_WINDOW);

   vsd_win_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(sel_wr_i), .run(run),
      .tick(win_tick_i), .win_end(win_end), .half_pt(half_pt)
   );

   vsd_pulse_cnt #(.THRESH(THRESH)) u_count (
      .clk(clk), .rst_n(rst_n), .clr(sel_wr_i), .run(run),
      .pulse(sync_pulse_i), .win_end(win_end), .win_hi(win_hi)
   );

   vsd_decide u_decide (
      .clk(clk), .rst_n(rst_n), .clr(sel_wr_i), .run(run),
      .win_end(win_end), .win_hi(win_hi), .half_pt(half_pt),
      .upd(upd), .upd_val(upd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            src_q <= '0;
      else if (sel_wr_i)     src_q <= src_sel_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flag_q <= 1'b0;
      else if (sel_wr_i || !src_act)   flag_q <= 1'b0;
      else if (mode == MODE_STICKY) begin
         if (sync_pulse_i)             flag_q <= 1'b1;
         else if (stat_rd_i)           flag_q <= 1'b0;
      end else if (upd)                flag_q <= upd_val;
   end

   assign detect_o = flag_q;
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker (
   input logic clk,
   input logic rst_n,
   input logic sync_pulse_i,
   input logic mode_i,
   input logic sel_wr_i,
   input logic stat_rd_i,
   input logic detect_o,
   input logic src_act,
   input logic upd,
   input logic upd_val,
   input logic win_end,
   input logic half_pt
);
   assert_sel_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr_i |=> !detect_o);

   assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !src_act |-> !detect_o);

   assert_sticky_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_act && !mode_i && sync_pulse_i && !sel_wr_i) |=> detect_o);

   assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_act && !mode_i && stat_rd_i && !sync_pulse_i && !sel_wr_i) |=> !detect_o);

   assert_window_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && !sel_wr_i && !upd) |=> $stable(detect_o));

   assert_update_val_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !sel_wr_i) |=> (detect_o == $past(upd_val)));

   assert_edges_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_end && half_pt));
endmodule

bind vsd_presence_det vsd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .sync_pulse_i(sync_pulse_i), .mode_i(mode_i),
   .sel_wr_i(sel_wr_i), .stat_rd_i(stat_rd_i), .detect_o(detect_o),
   .src_act(src_act), .upd(upd), .upd_val(upd_val),
   .win_end(win_end), .half_pt(half_pt)
);

// File: tb/tb_vsd_presence_det.sv
module tb_vsd_presence_det;
   localparam int W    = 8;
   localparam int HALF = W / 2;
   localparam int TP   = 64;
   localparam int NWIN = 10;

   // pulses per window, then {flag before half point, flag after it}
   localparam int       NP  [NWIN] = '{400, 400, 100, 384, 383, 383, 0, 512, 384, 0};
   localparam bit [1:0] EXP [NWIN] = '{2'b00, 2'b00, 2'b01, 2'b11, 2'b11,
                                       2'b11, 2'b10, 2'b00, 2'b00, 2'b01};

   logic clk = 1'b0, rst_n = 1'b0;
   logic sync_pulse_i = 0, win_tick_i = 0, mode_i = 0, sel_wr_i = 0, stat_rd_i = 0;
   logic [2:0] src_sel_i = '0;
   logic detect_o;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   vsd_presence_det #(.WIN_TICKS(W), .THRESH(384)) dut (
      .clk(clk), .rst_n(rst_n), .sync_pulse_i(sync_pulse_i), .win_tick_i(win_tick_i),
      .mode_i(mode_i), .src_sel_i(src_sel_i), .sel_wr_i(sel_wr_i),
      .stat_rd_i(stat_rd_i), .detect_o(detect_o)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic drive(input bit p, input bit t, input bit rd, input bit wr);
      @(negedge clk);
      sync_pulse_i = p; win_tick_i = t; stat_rd_i = rd; sel_wr_i = wr;
   endtask

   task automatic sel_write(input logic [2:0] s, input bit m);
      @(negedge clk);
      sync_pulse_i = 0; win_tick_i = 0; stat_rd_i = 0;
      src_sel_i = s; mode_i = m; sel_wr_i = 1;
      @(negedge clk);
      sel_wr_i = 0;
      chk(detect_o, 1'b0, "R3 select write clears");
   endtask

   task automatic run_win(input int np, input bit pre, input bit mid, input string tag);
      int c = 0;
      for (int t = 0; t < W; t++) begin
         for (int p = 0; p < TP; p++) begin
            @(negedge clk);
            if (t == HALF - 1 && p == TP - 1) chk(detect_o, pre, {tag, " before half"});
            if (t == HALF && p == 0)          chk(detect_o, mid, {tag, " after half"});
            sync_pulse_i = (c < np); win_tick_i = (p == TP - 1);
            stat_rd_i = 0; sel_wr_i = 0;
            c++;
         end
      end
      @(negedge clk);
      sync_pulse_i = 0; win_tick_i = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(detect_o, 1'b0, "R1 flag low in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(detect_o, 1'b0, "R1 flag low after reset");
      drive(1, 0, 0, 0);
      drive(0, 0, 0, 0);
      chk(detect_o, 1'b0, "R1 R2 reset code selects nothing");

      // windowed mode table: R6 R7 R8 R9 R10
      sel_write(3'd1, 1'b1);
      for (int i = 0; i < NWIN; i++)
         run_win(NP[i], EXP[i][1], EXP[i][0], $sformatf("R7 R8 R9 R10 window %0d", i));

      // R11: status read in windowed mode leaves flag
      drive(0, 0, 1, 0);
      drive(0, 0, 0, 0);
      chk(detect_o, 1'b1, "R11 read ignored in mode 1");

      // R3 / R6: mid-window select write restarts timing
      sel_write(3'd1, 1'b1);
      for (int k = 0; k < HALF * TP; k++) drive(1, (k % TP) == TP - 1, 0, 0);
      sel_write(3'd1, 1'b1);
      run_win(400, 0, 0, "R3 restart w0");
      run_win(400, 0, 0, "R3 restart w1");
      run_win(0,   0, 1, "R3 R10 restart w2");

      // R2: code 111 idle in mode 1
      sel_write(3'd7, 1'b1);
      run_win(512, 0, 0, "R2 code7 w0");
      run_win(512, 0, 0, "R2 code7 w1");
      run_win(512, 0, 0, "R2 code7 w2");

      // R2: idle codes in mode 0
      sel_write(3'd7, 1'b0);
      drive(1, 0, 0, 0); drive(0, 0, 0, 0);
      chk(detect_o, 1'b0, "R2 code7 sticky ignores pulse");
      sel_write(3'd0, 1'b0);
      drive(1, 0, 0, 0); drive(0, 0, 0, 0);
      chk(detect_o, 1'b0, "R2 code0 sticky ignores pulse");

      // R4 R5: sticky mode on live inputs
      sel_write(3'd6, 1'b0);
      drive(1, 0, 0, 0); drive(0, 0, 0, 0);
      chk(detect_o, 1'b1, "R4 R2 pulse sets on input 6");
      for (int k = 0; k < 20; k++) drive(0, (k % 4) == 3, 0, 0);
      chk(detect_o, 1'b1, "R4 flag held");
      drive(0, 0, 1, 0); drive(0, 0, 0, 0);
      chk(detect_o, 1'b0, "R5 read clears");
      drive(1, 0, 1, 0); drive(0, 0, 0, 0);
      chk(detect_o, 1'b1, "R5 pulse beats read");
      drive(1, 0, 1, 1); drive(0, 0, 0, 0);
      chk(detect_o, 1'b0, "R3 write beats pulse");
      drive(1, 0, 0, 0); drive(0, 0, 0, 0);
      chk(detect_o, 1'b1, "R4 sets after write");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule